// File: doc/BRIEF.md
# Banked Interrupt Priority Mask Unit

This block keeps the exception-masking state of a small microcontroller core and derives the execution priority that the interrupt logic compares pending requests against. It holds two single-bit masks: one that blocks every configurable exception and one that also blocks faults. It also holds an 8-bit base-priority threshold. When the security extension is built in, the threshold has one copy per security state. The security-state input chooses which copy is read, written and used.

Software reaches the registers through a small port addressed by a special-register number. It has a write strobe, write data and a combinational read path. Two numbers map onto the base-priority threshold. One is a plain store. The other is a conditional alias that only ever makes the threshold more restrictive, and it touches only the copy that is selected. The execution priority is a signed output computed combinationally from the registered state and a group-priority mask input.

Top module: `pmask_unit`

## Requirements
- R1: After reset every register copy reads as zero and the execution priority is 256.
- R2: A write to register number 17 stores bits [7:0] of the write data into the base-priority copy selected by `sec_state` (0 non-secure, 1 secure) and leaves the other copy unchanged.
- R3: A write to register number 18 changes the selected copy to bits [7:0] of the write data only if that value is nonzero and either is below the current value or the current value is zero. Otherwise the copy keeps its value.
- R4: Reads of register numbers 17 and 18 both return the selected base-priority copy, zero-extended to 32 bits.
- R5: A write to register number 16 stores only data bit 0 into the primask bit, and a write to number 19 stores only data bit 0 into the faultmask bit. Both read back in bit 0 with all other bits zero.
- R6: While the faultmask bit is set, the execution priority is -1 (10'h3FF).
- R7: While the faultmask bit is clear and the primask bit is set, the execution priority is 0.
- R8: With both mask bits clear and the selected base-priority copy nonzero, the execution priority is that copy ANDed with `grp_mask`. This holds even when the result is 0.
- R9: With both mask bits clear and the selected copy zero, the execution priority is 256.
- R10: Any register number other than 16 to 19 reads as zero, and a write to it changes no register.
- R11: With `wr_en` low, no register changes, whatever the address and data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_state | input | 1 | Current security state, 1 = secure |
| wr_en | input | 1 | Register write strobe |
| reg_num | input | 8 | Special-register number |
| wr_data | input | 32 | Write data |
| grp_mask | input | 8 | Group-priority mask applied to the base priority |
| rd_data | output | 32 | Read data for `reg_num` |
| exec_prio | output | 10 | Signed execution priority |

## Verification
A register write lands on the rising edge on which `wr_en` is high. Both `rd_data` and `exec_prio` are combinational from the registers, so every effect of a write is due in the cycle right after that edge, with no further latency. The bench drives a write at a falling edge and removes the strobe at the next falling edge. At the same moment it points `reg_num` at the register to read back. It samples one time unit later, so each check sees the state that the single write edge produced. Changes to `sec_state` and `grp_mask` alone need no edge, and they are checked within the same low phase.

// File: rtl/pmask_pkg.sv
package pmask_pkg;
   // special-register numbers decoded by the unit
   localparam int unsigned PMK_REG_PRIMASK   = 16;
   localparam int unsigned PMK_REG_BASE      = 17;
   localparam int unsigned PMK_REG_BASE_MAX  = 18;
   localparam int unsigned PMK_REG_FAULTMASK = 19;

   typedef enum logic [1:0] {
      RSEL_NONE  = 2'd0,
      RSEL_PRI   = 2'd1,
      RSEL_BASE  = 2'd2,
      RSEL_FAULT = 2'd3
   } pmk_rsel_e;

   typedef struct packed {
      logic      wr_pri;
      logic      wr_base;
      logic      wr_base_max;
      logic      wr_fault;
      pmk_rsel_e rsel;
   } pmk_dec_t;
endpackage

// File: rtl/pmask_decode.sv
module pmask_decode
   import pmask_pkg::*;
#(
   parameter int unsigned REGNUM_W = 8
) (
   input  logic                wr_en,
   input  logic [REGNUM_W-1:0] reg_num,
   output pmk_dec_t            dec
);
   always_comb begin
      dec = '{wr_pri: 1'b0, wr_base: 1'b0, wr_base_max: 1'b0,
              wr_fault: 1'b0, rsel: RSEL_NONE};
      if (reg_num == REGNUM_W'(PMK_REG_PRIMASK)) begin
         dec.rsel   = RSEL_PRI;
         dec.wr_pri = wr_en;
      end else if (reg_num == REGNUM_W'(PMK_REG_BASE)) begin
         dec.rsel    = RSEL_BASE;
         dec.wr_base = wr_en;
      end else if (reg_num == REGNUM_W'(PMK_REG_BASE_MAX)) begin
         dec.rsel        = RSEL_BASE;
         dec.wr_base_max = wr_en;
      end else if (reg_num == REGNUM_W'(PMK_REG_FAULTMASK)) begin
         dec.rsel     = RSEL_FAULT;
         dec.wr_fault = wr_en;
      end
   end
endmodule

// File: rtl/pmask_flag.sv
module pmask_flag #(
   parameter logic RESET_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wr,
   input  logic d,
   output logic q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= RESET_VAL;
      else if (wr) q <= d;
   end
endmodule

// File: rtl/pmask_base_bank.sv
module pmask_base_bank #(
   parameter int unsigned PRIO_W    = 8,
   parameter int unsigned NUM_BANKS = 2
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               sel,
   input  logic                               wr_plain,
   input  logic                               wr_max,
   input  logic [PRIO_W-1:0]                  wr_val,
   output logic [NUM_BANKS-1:0][PRIO_W-1:0]   bank_q,
   output logic [PRIO_W-1:0]                  cur
);
   generate
      if (NUM_BANKS < 1 || NUM_BANKS > 2) begin : g_bad_banks
         $error("pmask_base_bank: NUM_BANKS must be 1 or 2");
      end
   endgenerate

   genvar b;
   generate
      for (b = 0; b < NUM_BANKS; b++) begin : g_bank
         logic hit;
         logic tighten;
         assign hit     = (NUM_BANKS == 1) ? 1'b1 : (sel == 1'(b));
         assign tighten = (wr_val != '0) &&
                          ((wr_val < bank_q[b]) || (bank_q[b] == '0));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               bank_q[b] <= '0;
            else if (hit && (wr_plain || (wr_max && tighten)))
               bank_q[b] <= wr_val;
         end
      end

      if (NUM_BANKS == 1) begin : g_cur_one
         logic unused_sel;
         assign unused_sel = sel;
         assign cur = bank_q[0];
      end else begin : g_cur_two
         assign cur = sel ? bank_q[NUM_BANKS-1] : bank_q[0];
      end
   endgenerate
endmodule

// File: rtl/pmask_prio_calc.sv
module pmask_prio_calc #(
   parameter int unsigned PRIO_W = 8,
   parameter int unsigned OUT_W  = 10
) (
   input  logic                    fault,
   input  logic                    pri,
   input  logic [PRIO_W-1:0]       base,
   input  logic [PRIO_W-1:0]       grp_mask,
   output logic signed [OUT_W-1:0] prio
);
   localparam int unsigned NOEXC = 1 << PRIO_W;

   always_comb begin
      if (fault)
         prio = '1;
      else if (pri)
         prio = '0;
      else if (base != '0)
         prio = OUT_W'(base & grp_mask);
      else
         prio = OUT_W'(NOEXC);
   end
endmodule

// File: rtl/pmask_unit.sv
module pmask_unit
   import pmask_pkg::*;
#(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned REGNUM_W = 8,
   parameter int unsigned PRIO_W   = 8,
   parameter int unsigned OUT_W    = 10,
   parameter bit          SEC_EXT  = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    sec_state,
   input  logic                    wr_en,
   input  logic [REGNUM_W-1:0]     reg_num,
   input  logic [DATA_W-1:0]       wr_data,
   input  logic [PRIO_W-1:0]       grp_mask,
   output logic [DATA_W-1:0]       rd_data,
   output logic signed [OUT_W-1:0] exec_prio
);
   localparam int unsigned NUM_BANKS = SEC_EXT ? 2 : 1;

   generate
      if (OUT_W < PRIO_W + 2) begin : g_bad_out
         $error("pmask_unit: OUT_W too narrow for -1 and the idle value");
      end
      if (PRIO_W > DATA_W || DATA_W < 2) begin : g_bad_data
         $error("pmask_unit: DATA_W must hold a priority value");
      end
      if (REGNUM_W < 5) begin : g_bad_regnum
         $error("pmask_unit: REGNUM_W cannot encode register 19");
      end
   endgenerate

   pmk_dec_t                             dec;
   logic                                 bank_sel;
   logic [NUM_BANKS-1:0][PRIO_W-1:0]     bank_q;
   logic [PRIO_W-1:0]                    bp_sel;
   logic [PRIO_W-1:0]                    bp_ns;
   logic [PRIO_W-1:0]                    bp_s;
   logic                                 pri_q;
   logic                                 fault_q;
   logic [DATA_W-PRIO_W-1:0]             unused_hi;

   assign unused_hi = wr_data[DATA_W-1:PRIO_W];

   generate
      if (SEC_EXT) begin : g_sec
         assign bank_sel = sec_state;
         assign bp_s     = bank_q[NUM_BANKS-1];
      end else begin : g_nosec
         logic unused_sec;
         assign unused_sec = sec_state;
         assign bank_sel   = 1'b0;
         assign bp_s       = '0;
      end
   endgenerate
   assign bp_ns = bank_q[0];

   pmask_decode #(.REGNUM_W(REGNUM_W)) u_dec (
      .wr_en   (wr_en),
      .reg_num (reg_num),
      .dec     (dec)
   );

   pmask_base_bank #(.PRIO_W(PRIO_W), .NUM_BANKS(NUM_BANKS)) u_base (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel      (bank_sel),
      .wr_plain (dec.wr_base),
      .wr_max   (dec.wr_base_max),
      .wr_val   (wr_data[PRIO_W-1:0]),
      .bank_q   (bank_q),
      .cur      (bp_sel)
   );

   pmask_flag #(.RESET_VAL(1'b0)) u_pri (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (dec.wr_pri),
      .d     (wr_data[0]),
      .q     (pri_q)
   );

   pmask_flag #(.RESET_VAL(1'b0)) u_fault (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (dec.wr_fault),
      .d     (wr_data[0]),
      .q     (fault_q)
   );

   pmask_prio_calc #(.PRIO_W(PRIO_W), .OUT_W(OUT_W)) u_prio (
      .fault    (fault_q),
      .pri      (pri_q),
      .base     (bp_sel),
      .grp_mask (grp_mask),
      .prio     (exec_prio)
   );

   always_comb begin
      unique case (dec.rsel)
         RSEL_PRI:   rd_data = DATA_W'(pri_q);
         RSEL_BASE:  rd_data = DATA_W'(bp_sel);
         RSEL_FAULT: rd_data = DATA_W'(fault_q);
         default:    rd_data = '0;
      endcase
   end
endmodule

// File: rtl/pmask_unit_chk.sv
module pmask_unit_chk #(
   parameter int unsigned REGNUM_W = 8,
   parameter int unsigned PRIO_W   = 8,
   parameter int unsigned OUT_W    = 10,
   parameter bit          SEC_EXT  = 1'b1
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    sec_state,
   input logic                    wr_en,
   input logic [REGNUM_W-1:0]     reg_num,
   input logic [PRIO_W-1:0]       wr_lo,
   input logic signed [OUT_W-1:0] exec_prio,
   input logic                    pri_q,
   input logic                    fault_q,
   input logic [PRIO_W-1:0]       bp_ns,
   input logic [PRIO_W-1:0]       bp_s,
   input logic [PRIO_W-1:0]       bp_sel
);
   logic known;
   assign known = (reg_num >= REGNUM_W'(16)) && (reg_num <= REGNUM_W'(19));

   // R6
   fault_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault_q |-> (exec_prio == -1));

   // R7
   pri_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!fault_q && pri_q) |-> (exec_prio == 0));

   // R9
   idle_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!fault_q && !pri_q && bp_sel == '0) |-> (exec_prio == OUT_W'(1 << PRIO_W)));

   // R3
   max_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && reg_num == REGNUM_W'(18) && wr_lo == '0)
      |=> ($stable(bp_ns) && $stable(bp_s)));

   // R3
   max_no_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && reg_num == REGNUM_W'(18) && bp_sel != '0 && wr_lo >= bp_sel)
      |=> ($stable(bp_ns) && $stable(bp_s)));

   // R10
   unknown_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !known)
      |=> ($stable(bp_ns) && $stable(bp_s) && $stable(pri_q) && $stable(fault_q)));

   // R11
   no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> ($stable(bp_ns) && $stable(bp_s) && $stable(pri_q) && $stable(fault_q)));

   generate
      if (SEC_EXT) begin : g_bank_chk
         // R2
         other_bank_s_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && !sec_state) |=> $stable(bp_s));
         // R2
         other_bank_ns_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && sec_state) |=> $stable(bp_ns));
      end
   endgenerate
endmodule

bind pmask_unit pmask_unit_chk #(
   .REGNUM_W (REGNUM_W),
   .PRIO_W   (PRIO_W),
   .OUT_W    (OUT_W),
   .SEC_EXT  (SEC_EXT)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .sec_state (sec_state),
   .wr_en     (wr_en),
   .reg_num   (reg_num),
   .wr_lo     (wr_data[PRIO_W-1:0]),
   .exec_prio (exec_prio),
   .pri_q     (pri_q),
   .fault_q   (fault_q),
   .bp_ns     (bp_ns),
   .bp_s      (bp_s),
   .bp_sel    (bp_sel)
);

// File: tb/pmask_unit_bench.sv
`timescale 1ns/1ps
module pmask_unit_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sec_state = 1'b0;
   logic        wr_en = 1'b0;
   logic [7:0]  reg_num = '0;
   logic [31:0] wr_data = '0;
   logic [7:0]  grp_mask = 8'hFF;
   logic [31:0] rd_data;
   logic signed [9:0] exec_prio;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   pmask_unit u_pmask_unit (
      .clk       (clk),
      .rst_n     (rst_n),
      .sec_state (sec_state),
      .wr_en     (wr_en),
      .reg_num   (reg_num),
      .wr_data   (wr_data),
      .grp_mask  (grp_mask),
      .rd_data   (rd_data),
      .exec_prio (exec_prio)
   );

   typedef struct packed {
      logic        sec;
      logic        we;
      logic [7:0]  regn;
      logic [31:0] wdata;
      logic [7:0]  gmask;
      logic [7:0]  rreg;
      logic [31:0] exp_rd;
      logic [9:0]  exp_prio;
      logic [7:0]  req;
   } vec_t;

   localparam int NV = 20;
   localparam vec_t VECS [NV] = '{
      '{1'b0,1'b1,8'd17,32'h0000_01A5,8'hFF,8'd17,32'hA5,10'd165,8'd2},  // R2 low byte kept
      '{1'b0,1'b0,8'd17,32'h0000_0033,8'hFF,8'd17,32'hA5,10'd165,8'd11}, // R11 no strobe
      '{1'b1,1'b0,8'd17,32'h0,        8'hFF,8'd17,32'h00,10'd256,8'd4},  // R4 secure copy untouched
      '{1'b1,1'b1,8'd18,32'h40,       8'hFF,8'd18,32'h40,10'd64, 8'd3},  // R3 from zero
      '{1'b1,1'b1,8'd18,32'h60,       8'hFF,8'd18,32'h40,10'd64, 8'd3},  // R3 larger refused
      '{1'b1,1'b1,8'd18,32'h100,      8'hFF,8'd18,32'h40,10'd64, 8'd3},  // R3 masked zero refused
      '{1'b1,1'b1,8'd18,32'h20,       8'hFF,8'd17,32'h20,10'd32, 8'd3},  // R3 smaller taken
      '{1'b0,1'b0,8'd18,32'h0,        8'hFF,8'd18,32'hA5,10'd165,8'd4},  // R4 alias read, ns copy kept
      '{1'b0,1'b0,8'd0, 32'h0,        8'hE0,8'd17,32'hA5,10'd160,8'd8},  // R8 group mask
      '{1'b0,1'b1,8'd17,32'hFFFF_FF00,8'hFF,8'd17,32'h00,10'd256,8'd9},  // R9 cleared
      '{1'b0,1'b1,8'd18,32'h0,        8'hFF,8'd18,32'h00,10'd256,8'd3},  // R3 zero on zero
      '{1'b0,1'b1,8'd18,32'h7,        8'hFF,8'd18,32'h07,10'd7,  8'd3},  // R3 any nonzero on zero
      '{1'b0,1'b1,8'd17,32'h0,        8'hFF,8'd17,32'h00,10'd256,8'd2},  // R2 plain store lowers
      '{1'b0,1'b1,8'd16,32'hFFFF_FFFE,8'hFF,8'd16,32'h00,10'd256,8'd5},  // R5 bit 0 only
      '{1'b0,1'b1,8'd16,32'h3,        8'hFF,8'd16,32'h01,10'd0,  8'd7},  // R7 primask
      '{1'b0,1'b1,8'd19,32'h5,        8'hFF,8'd19,32'h01,10'h3FF,8'd6},  // R6 faultmask
      '{1'b0,1'b1,8'd32,32'hFF,       8'hFF,8'd32,32'h00,10'h3FF,8'd10}, // R10 unknown number
      '{1'b0,1'b1,8'd19,32'h0,        8'hFF,8'd19,32'h00,10'd0,  8'd7},  // R7 after fault clear
      '{1'b0,1'b1,8'd16,32'h0,        8'hFF,8'd16,32'h00,10'd256,8'd9},  // R9 all clear
      '{1'b1,1'b0,8'd0, 32'h0,        8'h1F,8'd17,32'h20,10'd0,  8'd8}   // R8 masked to zero
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic chk_reset_state(input string req);
      for (int s = 0; s < 2; s++) begin
         sec_state = s[0];
         for (int r = 16; r < 20; r++) begin
            reg_num = 8'(r);
            #1;
            chk(req, rd_data, 32'h0);
         end
         chk(req, 32'(exec_prio), 32'(10'sd256));
      end
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk_reset_state("R1");

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         sec_state = VECS[i].sec;
         wr_en     = VECS[i].we;
         reg_num   = VECS[i].regn;
         wr_data   = VECS[i].wdata;
         grp_mask  = VECS[i].gmask;
         @(negedge clk);
         wr_en   = 1'b0;
         reg_num = VECS[i].rreg;
         #1;
         chk($sformatf("R%0d row %0d rd", VECS[i].req, i), rd_data, VECS[i].exp_rd);
         chk($sformatf("R%0d row %0d prio", VECS[i].req, i),
             32'(exec_prio), 32'(signed'(VECS[i].exp_prio)));
      end

      // R1: reset in mid-run clears both copies and the masks
      @(negedge clk);
      sec_state = 1'b0; wr_en = 1'b1; reg_num = 8'd19; wr_data = 32'h1;
      @(negedge clk);
      reg_num = 8'd16;
      @(negedge clk);
      wr_en = 1'b0;
      grp_mask = 8'hFF;
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk_reset_state("R1");

      // R2/R4: both copies hold different values at once
      @(negedge clk);
      sec_state = 1'b0; wr_en = 1'b1; reg_num = 8'd17; wr_data = 32'h11;
      @(negedge clk);
      sec_state = 1'b1; wr_data = 32'h22;
      @(negedge clk);
      wr_en = 1'b0; sec_state = 1'b0; reg_num = 8'd18;
      #1;
      chk("R4 ns copy", rd_data, 32'h11);
      sec_state = 1'b1;
      #1;
      chk("R4 s copy", rd_data, 32'h22);
      chk("R8 s prio", 32'(exec_prio), 32'(10'sd34));

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule